// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits between a host bus and the control logic of a byte-wide NOR flash. Each host write cycle carries a 17-bit address and a data byte. The decoder follows the multi-cycle unlock sequences that guard the destructive commands. When a sequence completes, it raises a one-clock pulse that names the command: reset, identifier-mode entry, byte program, chip erase, sector erase, erase suspend or erase resume. With the program pulse it also gives the program address and data, and with the sector erase pulse it gives the sector number. A wrong cycle anywhere in a sequence drops the sequence without a pulse and puts the decoder back into array read.

The decoder also keeps the read mode, array or identifier, and uses it to steer the read data path. In array mode, reads return the array byte supplied from outside. In identifier mode, reads return a maker code, a device code, or a per-sector protection flag taken from an 8-bit protection input. While an embedded operation runs, a busy input restricts the decoder to suspend and resume. An erase-window input lets further sector erase commands through during the erase start window.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset no command pulse is high, the read mode is array (`ident_mode`=0), and `rd_data` equals `array_data`.
- R2: The writes AA@555h, 55@2AAh, A0@555h and then D@A give one `cmd_program` pulse, with `prog_addr`=A and `prog_data`=D. Only address bits 10:0 are compared in the unlock and command cycles, so the upper bits may hold any value.
- R3: The writes AA@555h, 55@2AAh, 80@555h, AA@555h, 55@2AAh and 10@555h give one `cmd_chip_erase` pulse.
- R4: The same first five writes as in R3, followed by 30 at address S, give one `cmd_sector_erase` pulse with `sector`=S[16:14].
- R5: The writes AA@555h, 55@2AAh and 90@555h give one `cmd_ident` pulse and set `ident_mode`=1. In identifier mode, a read whose address bits 7:0 are 00h returns 01h, and one whose bits 7:0 are 01h returns 20h.
- R6: In identifier mode, a read at offset 02h returns `prot[rd_addr[16:14]]` in bit 0, with zeros in the other bits. Any other offset returns 00h. Reads may repeat without changing the mode.
- R7: Data F0 written at any address, outside the program data cycle, gives one `cmd_reset` pulse and returns the mode to array. The three-cycle form AA@555h, 55@2AAh, F0@555h behaves the same way.
- R8: A write whose address or data does not fit the sequence gives no pulse, clears the sequence and sets the mode to array. A complete sequence written next is still decoded.
- R9: When not busy and no sequence is open, data B0 at any address gives one `cmd_suspend` pulse and data 30 at any address gives one `cmd_resume` pulse.
- R10: While `busy`=1, writes give no reset, identifier, program or chip erase pulse, and they do not advance the sequence. B0 still gives `cmd_suspend`. Data 30 gives `cmd_sector_erase` with `sector`=addr[16:14] when `erase_window`=1, and `cmd_resume` otherwise.
- R11: Each command pulse lasts one clock, in the cycle after the accepting write, and at most one pulse is high at a time. `prog_addr` and `prog_data` hold until the next program pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | One-clock host write strobe |
| wr_addr | input | 17 | Write address |
| wr_data | input | 8 | Write data |
| busy | input | 1 | Embedded operation in progress |
| erase_window | input | 1 | Sector erase start window open |
| rd_addr | input | 17 | Read address |
| array_data | input | 8 | Byte read from the array |
| prot | input | 8 | Protection flag for each sector |
| rd_data | output | 8 | Read data after mode steering |
| ident_mode | output | 1 | 1 = identifier read mode |
| cmd_reset | output | 1 | Reset pulse |
| cmd_ident | output | 1 | Identifier entry pulse |
| cmd_program | output | 1 | Byte program pulse |
| cmd_chip_erase | output | 1 | Chip erase pulse |
| cmd_sector_erase | output | 1 | Sector erase pulse |
| cmd_suspend | output | 1 | Erase suspend pulse |
| cmd_resume | output | 1 | Erase resume pulse |
| prog_addr | output | 17 | Latched program address |
| prog_data | output | 8 | Latched program data |
| sector | output | 3 | Latched sector erase number |

## Verification
Complete program, chip erase and sector erase sequences are written with junk in the upper address bits of the unlock cycles. This shows that only the low address bits are compared, and that the two erase forms split only at the sixth cycle. Wrong-address and wrong-data cycles are placed in the middle of sequences, and again while in identifier mode. These cases separate a clean abort from a sequence left half open. Identifier reads sweep the three offsets across a protected and an unprotected sector, and the one-cycle and three-cycle resets are each used to leave the mode. A busy phase then replays a full program sequence and the single-cycle commands, with the erase window both closed and open. This shows which writes are dropped and how data 30 is routed.

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int AW   = 17,
  parameter int DW   = 8,
  parameter int CMPW = 11,
  parameter int SECW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic            busy,
  input  logic            erase_window,
  input  logic [AW-1:0]   rd_addr,
  input  logic [DW-1:0]   array_data,
  input  logic [(1<<SECW)-1:0] prot,
  output logic [DW-1:0]   rd_data,
  output logic            ident_mode,
  output logic            cmd_reset,
  output logic            cmd_ident,
  output logic            cmd_program,
  output logic            cmd_chip_erase,
  output logic            cmd_sector_erase,
  output logic            cmd_suspend,
  output logic            cmd_resume,
  output logic [AW-1:0]   prog_addr,
  output logic [DW-1:0]   prog_data,
  output logic [SECW-1:0] sector
);
  typedef enum logic [2:0] {S_IDLE, S_U1, S_U2, S_PROG, S_E1, S_E2, S_E3} seq_t;

  seq_t st, nst;
  logic nmode;
  logic n_rst, n_id, n_pg, n_ce, n_se, n_su, n_re;

  wire a555 = wr_addr[CMPW-1:0] == CMPW'(11'h555);
  wire a2aa = wr_addr[CMPW-1:0] == CMPW'(11'h2AA);
  wire [SECW-1:0] wr_sec = wr_addr[AW-1 -: SECW];
  wire [SECW-1:0] rd_sec = rd_addr[AW-1 -: SECW];

  always_comb begin
    nst = st;
    nmode = ident_mode;
    {n_rst, n_id, n_pg, n_ce, n_se, n_su, n_re} = '0;
    if (wr_en) begin
      if (busy) begin
        if (wr_data == 8'hB0) n_su = 1'b1;
        else if (wr_data == 8'h30) begin
          n_se = erase_window;
          n_re = !erase_window;
        end
      end else if (st == S_PROG) begin
        n_pg = 1'b1;
        nst = S_IDLE;
        nmode = 1'b0;
      end else if (wr_data == 8'hF0) begin
        n_rst = 1'b1;
        nst = S_IDLE;
        nmode = 1'b0;
      end else begin
        nst = S_IDLE;
        nmode = 1'b0;
        case (st)
          S_IDLE:
            if (wr_data == 8'hAA && a555) begin nst = S_U1; nmode = ident_mode; end
            else if (wr_data == 8'hB0) begin n_su = 1'b1; nmode = ident_mode; end
            else if (wr_data == 8'h30) begin n_re = 1'b1; nmode = ident_mode; end
          S_U1:
            if (wr_data == 8'h55 && a2aa) begin nst = S_U2; nmode = ident_mode; end
          S_U2:
            if (a555 && wr_data == 8'hA0) begin nst = S_PROG; nmode = ident_mode; end
            else if (a555 && wr_data == 8'h80) begin nst = S_E1; nmode = ident_mode; end
            else if (a555 && wr_data == 8'h90) begin n_id = 1'b1; nmode = 1'b1; end
          S_E1:
            if (wr_data == 8'hAA && a555) begin nst = S_E2; nmode = ident_mode; end
          S_E2:
            if (wr_data == 8'h55 && a2aa) begin nst = S_E3; nmode = ident_mode; end
          S_E3:
            if (wr_data == 8'h10 && a555) n_ce = 1'b1;
            else if (wr_data == 8'h30) n_se = 1'b1;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      ident_mode <= 1'b0;
      {cmd_reset, cmd_ident, cmd_program, cmd_chip_erase,
       cmd_sector_erase, cmd_suspend, cmd_resume} <= '0;
      prog_addr <= '0;
      prog_data <= '0;
      sector <= '0;
    end else begin
      st <= nst;
      ident_mode <= nmode;
      {cmd_reset, cmd_ident, cmd_program, cmd_chip_erase,
       cmd_sector_erase, cmd_suspend, cmd_resume} <= {n_rst, n_id, n_pg, n_ce, n_se, n_su, n_re};
      if (n_pg) begin
        prog_addr <= wr_addr;
        prog_data <= wr_data;
      end
      if (n_se) sector <= wr_sec;
    end
  end

  always_comb begin
    if (!ident_mode) rd_data = array_data;
    else case (rd_addr[7:0])
      8'h00:   rd_data = DW'(8'h01);
      8'h01:   rd_data = DW'(8'h20);
      8'h02:   rd_data = DW'(prot[rd_sec]);
      default: rd_data = '0;
    endcase
  end

  p_onehot_pulses_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_reset, cmd_ident, cmd_program, cmd_chip_erase,
              cmd_sector_erase, cmd_suspend, cmd_resume}));

  p_pulse_after_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_reset || cmd_ident || cmd_program || cmd_chip_erase ||
     cmd_sector_erase || cmd_suspend || cmd_resume) |-> $past(wr_en));

  p_prog_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_program |-> ($stable(prog_addr) && $stable(prog_data)));

  p_busy_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en) |=> !(cmd_reset || cmd_ident || cmd_program || cmd_chip_erase));

  p_chip_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_chip_erase |-> $past(wr_data) == 8'h10);

  p_ident_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ident_mode) |-> cmd_ident);
endmodule

// File: tb/test_flash_cmd_decoder.sv
`timescale 1ns/1ps
module test_flash_cmd_decoder;
  logic clk = 0, rst_n = 0, wr_en = 0, busy = 0, erase_window = 0;
  logic [16:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0, array_data = 8'hC3, prot = 8'b0000_1000;
  logic [7:0] rd_data;
  logic ident_mode, cmd_reset, cmd_ident, cmd_program, cmd_chip_erase;
  logic cmd_sector_erase, cmd_suspend, cmd_resume;
  logic [16:0] prog_addr;
  logic [7:0] prog_data;
  logic [2:0] sector;
  logic [6:0] last_p;
  int n_chk = 0, n_bad = 0;

  localparam logic [6:0] P_NONE = 7'b0, P_RST = 7'b1000000, P_ID = 7'b0100000,
    P_PG = 7'b0010000, P_CE = 7'b0001000, P_SE = 7'b0000100, P_SU = 7'b0000010,
    P_RE = 7'b0000001;

  always #4 clk = ~clk;

  flash_cmd_decoder i_flash_cmd_decoder (.*);

  wire [6:0] pulses = {cmd_reset, cmd_ident, cmd_program, cmd_chip_erase,
                       cmd_sector_erase, cmd_suspend, cmd_resume};

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [16:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
    last_p = pulses;
  endtask

  task automatic unlock();
    wr(17'h1D555, 8'hAA);
    wr(17'h0A2AA, 8'h55);
  endtask

  task automatic rd(string tag, logic [16:0] a, logic [7:0] exp);
    rd_addr = a;
    #1;
    chk(tag, rd_data, exp);
  endtask

  task automatic t_reset_state();
    chk("R1 pulses", pulses, P_NONE);
    chk("R1 mode", ident_mode, 0);
    rd("R1 array read", 17'h00000, 8'hC3);
  endtask

  task automatic t_program();
    unlock();
    chk("R2 no pulse mid", last_p, P_NONE);
    wr(17'h18555, 8'hA0);
    chk("R2 no pulse before data", last_p, P_NONE);
    wr(17'h1ABCD, 8'h5A);
    chk("R2 pulse", last_p, P_PG);
    chk("R2 addr", prog_addr, 17'h1ABCD);
    chk("R2 data", prog_data, 8'h5A);
    @(negedge clk);
    chk("R11 one cycle", pulses, P_NONE);
  endtask

  task automatic t_chip();
    unlock(); wr(17'h00555, 8'h80); unlock();
    chk("R3 no pulse mid", last_p, P_NONE);
    wr(17'h10555, 8'h10);
    chk("R3 pulse", last_p, P_CE);
    chk("R11 addr hold", prog_addr, 17'h1ABCD);
    chk("R11 data hold", prog_data, 8'h5A);
  endtask

  task automatic t_sector();
    unlock(); wr(17'h00555, 8'h80); unlock();
    wr(17'h14123, 8'h30);
    chk("R4 pulse", last_p, P_SE);
    chk("R4 sector", sector, 3'd5);
  endtask

  task automatic t_ident();
    unlock(); wr(17'h00555, 8'h90);
    chk("R5 pulse", last_p, P_ID);
    chk("R5 mode", ident_mode, 1);
    rd("R5 maker", 17'h1F300, 8'h01);
    rd("R5 device", 17'h00401, 8'h20);
    rd("R6 protected", 17'h0C002, 8'h01);
    rd("R6 unprotected", 17'h08002, 8'h00);
    rd("R6 repeat", 17'h0C002, 8'h01);
    rd("R6 other offset", 17'h0C003, 8'h00);
    wr(17'h12345, 8'hF0);
    chk("R7 one-cycle pulse", last_p, P_RST);
    chk("R7 mode", ident_mode, 0);
    rd("R7 array again", 17'h00000, 8'hC3);
  endtask

  task automatic t_reset3();
    unlock(); wr(17'h00555, 8'h90);
    unlock();
    wr(17'h00555, 8'hF0);
    chk("R7 three-cycle pulse", last_p, P_RST);
    chk("R7 three-cycle mode", ident_mode, 0);
  endtask

  task automatic t_abort();
    wr(17'h00555, 8'hAA);
    wr(17'h002AB, 8'h55);
    chk("R8 bad addr", last_p, P_NONE);
    wr(17'h00555, 8'hA0);
    wr(17'h00100, 8'h77);
    chk("R8 no program", last_p, P_NONE);
    unlock(); wr(17'h00555, 8'h81);
    chk("R8 bad data", last_p, P_NONE);
    unlock(); wr(17'h00555, 8'h90);
    wr(17'h00000, 8'h12);
    chk("R8 mode cleared", ident_mode, 0);
    unlock(); wr(17'h00555, 8'hA0); wr(17'h00042, 8'h99);
    chk("R8 recovers", last_p, P_PG);
    chk("R8 recovers data", prog_data, 8'h99);
  endtask

  task automatic t_susp_res();
    wr(17'h0ABCD, 8'hB0);
    chk("R9 suspend", last_p, P_SU);
    wr(17'h13333, 8'h30);
    chk("R9 resume", last_p, P_RE);
  endtask

  task automatic t_busy();
    busy = 1;
    unlock(); wr(17'h00555, 8'hA0); wr(17'h00011, 8'h22);
    chk("R10 program dropped", last_p, P_NONE);
    chk("R10 addr kept", prog_addr, 17'h00042);
    wr(17'h00000, 8'hF0);
    chk("R10 reset dropped", last_p, P_NONE);
    wr(17'h00000, 8'hB0);
    chk("R10 suspend", last_p, P_SU);
    wr(17'h00000, 8'h30);
    chk("R10 resume", last_p, P_RE);
    erase_window = 1;
    wr(17'h0C000, 8'h30);
    chk("R10 window sector", last_p, P_SE);
    chk("R10 window number", sector, 3'd3);
    erase_window = 0; busy = 0;
    wr(17'h00123, 8'h44);
    chk("R10 sequence not advanced", last_p, P_NONE);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset_state();
    t_program();
    t_chip();
    t_sector();
    t_ident();
    t_reset3();
    t_abort();
    t_susp_res();
    t_busy();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule